// File: doc/BRIEF.md
# Single-Wire Pulse-Width Serial Responder

This block is the device end of a single-wire, return-to-one serial link. The wire idles high through a pullup. Both ends can only pull it low. The host opens each transaction by holding the wire low for a long time, which is a break. It then sends an 8-bit command as eight time slots, and the width of the low pulse in each slot gives the value of that bit. The block watches the wire, resolves each bit by measuring that low width in clock cycles, and carries out a single-byte register access.

When the command selects a write, the block takes the next eight host slots as a data byte and issues a one-cycle write strobe on its internal register port. When the command selects a read, it issues a one-cycle read request and takes the read data in the following cycle. After a turnaround delay it sends the byte back by pulling the wire low: a short pulse for a 1 and a long pulse for a 0, one pulse per fixed-length slot. Each transaction carries exactly one byte. The block never starts traffic on its own. All pulse thresholds and timings are parameters counted in clock cycles.

Top module: `swr_responder`

## Requirements
- R1: While reset is held and right after it is released, `line_pull_o`, `reg_wr_o` and `reg_rd_o` are all 0.
- R2: A filtered low level lasting at least `BREAK_CYC` cycles is a break. Whatever state the block is in, a break aborts that state and makes the block wait for a fresh command from bit 0. A command or data byte that the break cut short has no effect.
- R3: A host bit is 1 when its filtered low pulse lasts fewer than `BIT_THRESH_CYC` cycles and 0 otherwise, so `BIT_THRESH_CYC-1` cycles gives 1 and `BIT_THRESH_CYC` cycles gives 0. Command bits arrive least significant first. Bits 0 to 6 are the register address and bit 7 is the direction: 1 selects write and 0 selects read.
- R4: After a write command, the next eight host bits (least significant first) form the data byte. The block then raises `reg_wr_o` for exactly one cycle, with `reg_addr_o` and `reg_wdata_o` holding the address and the byte.
- R5: After a read command, the block raises `reg_rd_o` for exactly one cycle with the address on `reg_addr_o`, and takes `reg_rdata_i` on the cycle that follows.
- R6: A read answer is exactly eight pulses on `line_pull_o`, least significant bit first, with pulse starts `DEV_SLOT_CYC` cycles apart. A pulse lasts `DEV_ONE_CYC` cycles for a 1 and `DEV_ZERO_CYC` cycles for a 0.
- R7: The first answer pulse starts at least `TURN_CYC` cycles after the host releases the wire at the end of the last command bit.
- R8: A low pulse on the wire shorter than `GLITCH_CYC` cycles is ignored. It does not add a bit or change the value of any bit.
- R9: Each transaction moves one byte. Host slots that follow the data byte without a new break cause no register access and no pulses.
- R10: The block only pulls the wire low or releases it. It pulls only while sending a read answer, and it produces no pulses or register strobes while the wire idles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Level sensed on the shared wire (asynchronous) |
| line_pull_o | output | 1 | 1 enables the open-drain pulldown on the wire |
| reg_addr_o | output | 7 | Register address decoded from the command |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Byte to write, valid with `reg_wr_o` |
| reg_rd_o | output | 1 | One-cycle read request |
| reg_rdata_i | input | 8 | Read data, valid on the cycle after `reg_rd_o` |

## Verification
The hardest cases to reach from the ports are a break that lands partway through a command or partway through a data byte, and pulse widths that sit exactly on the decode threshold. The bench reaches them with a host model that drives the wire cycle by cycle. It can stop a byte after any number of bits and send a new break. It can set the low widths to one cycle either side of the threshold, and it can insert sub-filter glitches into the high part of each slot. Over a sweep of every register address, the expected bytes come from arithmetic functions of the address. They are compared with the bytes decoded from the widths of the block's own answer pulses.

// File: rtl/swr_pkg.sv
package swr_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_WDATA,
    S_RD_WAIT,
    S_RD_CAP,
    S_TURN,
    S_TX
  } swr_state_t;

endpackage

// File: rtl/swr_line_filter.sv
module swr_line_filter #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic filt_o
);

  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
    end
  end

  generate
    if (GLITCH_CYC > 1) begin : g_filter
      localparam int GW = $clog2(GLITCH_CYC);
      logic [GW-1:0] gcnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          gcnt   <= '0;
          filt_o <= 1'b1;
        end else if (s2 == filt_o) begin
          gcnt <= '0;
        end else if (gcnt == GW'(GLITCH_CYC - 1)) begin
          gcnt   <= '0;
          filt_o <= s2;
        end else begin
          gcnt <= gcnt + GW'(1);
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) filt_o <= 1'b1;
        else     filt_o <= s2;
      end
    end
  endgenerate

endmodule

// File: rtl/swr_pulse_rx.sv
module swr_pulse_rx #(
  parameter int BREAK_CYC      = 200,
  parameter int BIT_THRESH_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic filt_i,
  output logic brk_o,
  output logic bit_vld_o,
  output logic bit_o
);

  localparam int CW = $clog2(BREAK_CYC + 1);

  logic [CW-1:0] low_cnt;
  logic          filt_q;
  logic          in_brk;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      filt_q    <= 1'b1;
      in_brk    <= 1'b0;
      brk_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
    end else begin
      filt_q    <= filt_i;
      brk_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      if (!filt_i) begin
        if (low_cnt != CW'(BREAK_CYC)) low_cnt <= low_cnt + CW'(1);
        if (low_cnt == CW'(BREAK_CYC - 1)) begin
          brk_o  <= 1'b1;
          in_brk <= 1'b1;
        end
      end else begin
        low_cnt <= '0;
        if (!filt_q) begin
          if (!in_brk) begin
            bit_vld_o <= 1'b1;
            bit_o     <= (low_cnt < CW'(BIT_THRESH_CYC));
          end
          in_brk <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/swr_pulse_tx.sv
module swr_pulse_tx #(
  parameter int DEV_ONE_CYC  = 30,
  parameter int DEV_ZERO_CYC = 120,
  parameter int DEV_SLOT_CYC = 190
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic [7:0] byte_i,
  output logic       pull_o,
  output logic       done_o
);

  localparam int SW = $clog2(DEV_SLOT_CYC);

  logic          busy, nbusy;
  logic [7:0]    sh, nsh;
  logic [2:0]    bc, nbc;
  logic [SW-1:0] sc, nsc;
  logic          ndone;
  logic [SW-1:0] nlen;

  always_comb begin
    nbusy = busy;
    nsh   = sh;
    nbc   = bc;
    nsc   = sc;
    ndone = 1'b0;
    if (abort_i) begin
      nbusy = 1'b0;
    end else if (busy) begin
      if (sc == SW'(DEV_SLOT_CYC - 1)) begin
        nsc = '0;
        nsh = {1'b0, sh[7:1]};
        nbc = bc + 3'd1;
        if (bc == 3'd7) begin
          nbusy = 1'b0;
          ndone = 1'b1;
        end
      end else begin
        nsc = sc + SW'(1);
      end
    end else if (start_i) begin
      nbusy = 1'b1;
      nsh   = byte_i;
      nbc   = 3'd0;
      nsc   = '0;
    end
    nlen = nsh[0] ? SW'(DEV_ONE_CYC) : SW'(DEV_ZERO_CYC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sh     <= '0;
      bc     <= '0;
      sc     <= '0;
      pull_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      busy   <= nbusy;
      sh     <= nsh;
      bc     <= nbc;
      sc     <= nsc;
      pull_o <= nbusy && (nsc < nlen);
      done_o <= ndone;
    end
  end

  AST_PULL_WITHIN_SLOT: assert property (@(posedge clk) disable iff (rst)
    pull_o |-> (busy && sc < SW'(DEV_ZERO_CYC))); // R6

endmodule

// File: rtl/swr_responder.sv
module swr_responder
  import swr_pkg::*;
#(
  parameter int BREAK_CYC      = 200,
  parameter int GLITCH_CYC     = 4,
  parameter int BIT_THRESH_CYC = 50,
  parameter int TURN_CYC       = 100,
  parameter int DEV_ONE_CYC    = 30,
  parameter int DEV_ZERO_CYC   = 120,
  parameter int DEV_SLOT_CYC   = 190
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  output logic              line_pull_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);

  localparam int TW = $clog2(TURN_CYC + 1);

  logic filt;
  logic brk, bit_vld, bit_val;
  logic tx_start, tx_done;
  logic [BYTE_W-1:0] tx_byte;

  swr_state_t        state;
  logic [BYTE_W-1:0] sh;
  logic [2:0]        bcnt;
  logic [TW-1:0]     turn_cnt;

  swr_line_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
    .clk    (clk),
    .rst    (rst),
    .line_i (line_i),
    .filt_o (filt)
  );

  swr_pulse_rx #(.BREAK_CYC(BREAK_CYC), .BIT_THRESH_CYC(BIT_THRESH_CYC)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .filt_i    (filt),
    .brk_o     (brk),
    .bit_vld_o (bit_vld),
    .bit_o     (bit_val)
  );

  swr_pulse_tx #(
    .DEV_ONE_CYC  (DEV_ONE_CYC),
    .DEV_ZERO_CYC (DEV_ZERO_CYC),
    .DEV_SLOT_CYC (DEV_SLOT_CYC)
  ) u_tx (
    .clk     (clk),
    .rst     (rst),
    .start_i (tx_start),
    .abort_i (brk),
    .byte_i  (tx_byte),
    .pull_o  (line_pull_o),
    .done_o  (tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      sh          <= '0;
      bcnt        <= '0;
      turn_cnt    <= '0;
      reg_addr_o  <= '0;
      reg_wr_o    <= 1'b0;
      reg_wdata_o <= '0;
      reg_rd_o    <= 1'b0;
      tx_byte     <= '0;
      tx_start    <= 1'b0;
    end else begin
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
      tx_start <= 1'b0;
      if (brk) begin
        state <= S_CMD;
        bcnt  <= 3'd0;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_CMD: begin
            if (bit_vld) begin
              sh   <= {bit_val, sh[7:1]};
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                reg_addr_o <= sh[7:1];
                if (bit_val) begin
                  state <= S_WDATA;
                end else begin
                  reg_rd_o <= 1'b1;
                  state    <= S_RD_WAIT;
                end
              end
            end
          end
          S_WDATA: begin
            if (bit_vld) begin
              sh   <= {bit_val, sh[7:1]};
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                reg_wdata_o <= {bit_val, sh[7:1]};
                reg_wr_o    <= 1'b1;
                state       <= S_IDLE;
              end
            end
          end
          S_RD_WAIT: state <= S_RD_CAP;
          S_RD_CAP: begin
            tx_byte  <= reg_rdata_i;
            turn_cnt <= '0;
            state    <= S_TURN;
          end
          S_TURN: begin
            if (turn_cnt == TW'(TURN_CYC - 1)) begin
              tx_start <= 1'b1;
              state    <= S_TX;
            end else begin
              turn_cnt <= turn_cnt + TW'(1);
            end
          end
          S_TX: if (tx_done) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_BRK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    brk |=> (state == S_CMD && bcnt == 3'd0)); // R2

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o); // R4

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_rd_o |=> !reg_rd_o); // R5

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_o && reg_rd_o)); // R9

  AST_PULL_ONLY_TX: assert property (@(posedge clk) disable iff (rst)
    line_pull_o |-> (state == S_TX)); // R10

endmodule

// File: tb/swr_responder_tb.sv
module swr_responder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BRK  = 40;
  localparam int GL   = 3;
  localparam int THR  = 12;
  localparam int TURN = 10;
  localparam int D1   = 5;
  localparam int D0   = 14;
  localparam int DS   = 24;
  localparam int H1   = 4;
  localparam int H0   = 20;
  localparam int HS   = 30;
  localparam int BRK_LOW = 50;
  localparam int REC     = 10;
  localparam int TX_WAIT = GL + 6 + TURN + 8 * DS + 20;

  logic       clk;
  logic       rst;
  logic       host_pull;
  logic       line_w;
  logic       line_pull_o;
  logic [6:0] reg_addr_o;
  logic       reg_wr_o;
  logic [7:0] reg_wdata_o;
  logic       reg_rd_o;
  logic [7:0] rdata_q;

  assign line_w = ~(host_pull | line_pull_o);

  swr_responder #(
    .BREAK_CYC(BRK), .GLITCH_CYC(GL), .BIT_THRESH_CYC(THR), .TURN_CYC(TURN),
    .DEV_ONE_CYC(D1), .DEV_ZERO_CYC(D0), .DEV_SLOT_CYC(DS)
  ) u_dut (
    .clk(clk), .rst(rst), .line_i(line_w), .line_pull_o(line_pull_o),
    .reg_addr_o(reg_addr_o), .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rd_o(reg_rd_o), .reg_rdata_i(rdata_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int pulse_cnt = 0;
  int cur_w = 0;
  int pw[8];
  int pstart[8];
  logic pull_prev = 1'b0;
  logic [6:0] last_waddr, last_raddr;
  logic [7:0] last_wdata;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  int h1_w = H1;
  int h0_w = H0;
  bit glitch_en = 0;
  int t_rel = 0;
  int trel_cmd = 0;

  function automatic logic [7:0] f_init(int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  function automatic logic [7:0] f_wr(int a);
    return 8'(((a * 53) ^ 8'hA5) & 255);
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (reg_rd_o) rdata_q <= mem[reg_addr_o];
    if (reg_wr_o) mem[reg_addr_o] <= reg_wdata_o;
    if (!rst) begin
      if (reg_wr_o) begin
        wr_cnt = wr_cnt + 1;
        last_waddr = reg_addr_o;
        last_wdata = reg_wdata_o;
      end
      if (reg_rd_o) begin
        rd_cnt = rd_cnt + 1;
        last_raddr = reg_addr_o;
      end
      if (line_pull_o && !pull_prev) pstart[pulse_cnt % 8] = cyc;
      if (line_pull_o) cur_w = cur_w + 1;
      if (!line_pull_o && pull_prev) begin
        pw[pulse_cnt % 8] = cur_w;
        pulse_cnt = pulse_cnt + 1;
        cur_w = 0;
      end
      pull_prev = line_pull_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    int lw;
    lw = b ? h1_w : h0_w;
    host_pull = 1'b1;
    repeat (lw) @(negedge clk);
    host_pull = 1'b0;
    t_rel = cyc;
    if (glitch_en) begin
      repeat (5) @(negedge clk);
      host_pull = 1'b1;
      repeat (GL - 1) @(negedge clk);
      host_pull = 1'b0;
      repeat (HS - lw - 5 - (GL - 1)) @(negedge clk);
    end else begin
      repeat (HS - lw) @(negedge clk);
    end
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic host_break();
    host_pull = 1'b1;
    repeat (BRK_LOW) @(negedge clk);
    host_pull = 1'b0;
    repeat (REC) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    host_break();
    send_bits({1'b1, a}, 8);
    send_bits(d, 8);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_read(input logic [6:0] a);
    host_break();
    send_bits({1'b0, a}, 8);
    trel_cmd = t_rel;
    repeat (TX_WAIT) @(negedge clk);
  endtask

  task automatic check_write(input logic [6:0] a, input logic [7:0] d, input int wc0, input string req);
    chk(wr_cnt - wc0 == 1, req, "write strobe count", wr_cnt - wc0, 1);
    chk(last_waddr == a && last_wdata == d, req, "write addr/data",
        int'({last_waddr, last_wdata}), int'({a, d}));
  endtask

  task automatic read_and_check(input logic [6:0] a, input logic [7:0] e);
    int pc0, rc0;
    logic [7:0] got;
    bit shape_ok;
    pc0 = pulse_cnt;
    rc0 = rd_cnt;
    do_read(a);
    chk(rd_cnt - rc0 == 1 && last_raddr == a, "R5", "read strobe/addr", int'(last_raddr), int'(a));
    chk(pulse_cnt - pc0 == 8, "R6", "answer pulse count", pulse_cnt - pc0, 8);
    shape_ok = 1;
    got = '0;
    for (int i = 0; i < 8; i++) begin
      got[i] = (pw[(pc0 + i) % 8] < (D1 + D0) / 2);
      if (pw[(pc0 + i) % 8] != (e[i] ? D1 : D0)) shape_ok = 0;
      if (i > 0 && pstart[(pc0 + i) % 8] - pstart[(pc0 + i - 1) % 8] != DS) shape_ok = 0;
    end
    chk(got == e, "R6", "answer byte", int'(got), int'(e));
    chk(shape_ok, "R6", "pulse widths and slot spacing", int'(shape_ok), 1);
    chk(pstart[pc0 % 8] - trel_cmd >= TURN, "R7", "turnaround cycles",
        pstart[pc0 % 8] - trel_cmd, TURN);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    summary();
    $finish;
  end

  initial begin
    int wc0, rc0, pc0;
    for (int a = 0; a < 128; a++) begin
      mem[a] = f_init(a);
      exp_mem[a] = f_init(a);
    end
    rdata_q = '0;
    host_pull = 1'b0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(!line_pull_o && !reg_wr_o && !reg_rd_o, "R1", "outputs in reset",
        int'({line_pull_o, reg_wr_o, reg_rd_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!line_pull_o && !reg_wr_o && !reg_rd_o, "R1", "outputs after reset",
        int'({line_pull_o, reg_wr_o, reg_rd_o}), 0);

    // R10: idle wire, nothing happens
    repeat (300) @(negedge clk);
    chk(pulse_cnt == 0 && wr_cnt == 0 && rd_cnt == 0, "R10", "idle activity",
        pulse_cnt + wr_cnt + rd_cnt, 0);

    // R3/R5/R6/R7: read sweep over every address
    for (int a = 0; a < 128; a++) read_and_check(7'(a), exp_mem[a]);

    // R4/R10: write sweep, no pulses expected while writing
    pc0 = pulse_cnt;
    for (int a = 0; a < 128; a++) begin
      wc0 = wr_cnt;
      do_write(7'(a), f_wr(a));
      exp_mem[a] = f_wr(a);
      check_write(7'(a), f_wr(a), wc0, "R4");
    end
    chk(pulse_cnt == pc0, "R10", "pulses during writes", pulse_cnt - pc0, 0);

    for (int i = 0; i < 16; i++) read_and_check(7'(i * 8 + 3), exp_mem[i * 8 + 3]);

    // R3: widths one cycle either side of the threshold
    h1_w = THR - 1;
    h0_w = THR;
    wc0 = wr_cnt;
    do_write(7'h2A, 8'hC3);
    exp_mem[7'h2A] = 8'hC3;
    check_write(7'h2A, 8'hC3, wc0, "R3");
    h1_w = H1;
    h0_w = H0;
    read_and_check(7'h2A, 8'hC3);

    // R2: break in the middle of a command
    wc0 = wr_cnt;
    rc0 = rd_cnt;
    host_break();
    send_bits(8'h05, 5);
    do_write(7'h11, 8'h96);
    exp_mem[7'h11] = 8'h96;
    check_write(7'h11, 8'h96, wc0, "R2");
    chk(rd_cnt == rc0, "R2", "stray read after cut command", rd_cnt - rc0, 0);

    // R2: break in the middle of a write data byte
    wc0 = wr_cnt;
    host_break();
    send_bits({1'b1, 7'h22}, 8);
    send_bits(8'h07, 3);
    do_write(7'h33, 8'h5A);
    exp_mem[7'h33] = 8'h5A;
    check_write(7'h33, 8'h5A, wc0, "R2");
    read_and_check(7'h22, exp_mem[7'h22]);

    // R8: glitches inside every slot
    glitch_en = 1;
    wc0 = wr_cnt;
    do_write(7'h44, 8'hA7);
    exp_mem[7'h44] = 8'hA7;
    check_write(7'h44, 8'hA7, wc0, "R8");
    read_and_check(7'h44, 8'hA7);
    glitch_en = 0;

    // R9: extra slots after a write
    wc0 = wr_cnt;
    do_write(7'h50, 8'h11);
    exp_mem[7'h50] = 8'h11;
    send_bits(8'h77, 8);
    send_bits(8'h88, 8);
    repeat (20) @(negedge clk);
    check_write(7'h50, 8'h11, wc0, "R9");
    chk(mem[7'h77] == exp_mem[7'h77], "R9", "register after extra slots",
        int'(mem[7'h77]), int'(exp_mem[7'h77]));

    // R9: extra slots after a read
    rc0 = rd_cnt;
    read_and_check(7'h50, 8'h11);
    pc0 = pulse_cnt;
    send_bits({1'b0, 7'h51}, 8);
    repeat (TX_WAIT) @(negedge clk);
    chk(rd_cnt - rc0 == 1, "R9", "read strobes per transaction", rd_cnt - rc0, 1);
    chk(pulse_cnt == pc0, "R9", "pulses after completed read", pulse_cnt - pc0, 0);

    summary();
    $finish;
  end

endmodule